// File: doc/BRIEF.md
# Four-Channel Periodic Interrupt Timer

This block produces periodic interrupt requests from four independent 16-bit down-counters. Two shared 8-bit prescalers each produce a stream of one-cycle ticks at a rate set by software. Each channel picks one of the two tick streams with a select bit. A channel counts down only on ticks from the stream it has selected. When it expires, it raises a time-out flag and reloads itself from its own load register.

Each channel's interrupt request is a level: its flag ANDed with its enable bit. Software clears a flag by writing a one to it. A channel can move from one tick stream to the other while it is running. The move takes effect at once and does not disturb the count in progress. One global run bit starts all counting and stops it again.

Software reaches the block through a plain write strobe, a 4-bit address and 16-bit write and read data. Reads are combinational from the addressed register. The map: 0 control (bit 0 = run), 1 tick select, 2 interrupt enable, 3 time-out flags, 4 prescaler A reload, 5 prescaler B reload, 8 to 11 channel 0 to 3 load values, 12 to 15 channel 0 to 3 current counts. Addresses 6 and 7 read as 0.

Top module: `pit_quad`

## Requirements
- R1: After reset, every register and counter reads 0 and `irq` is 0.
- R2: While running, a prescaler whose reload value is N gives one tick every N+1 cycles. After each tick it counts again from N.
- R3: A running channel decrements only on a tick from its selected prescaler. On a tick that finds its count at 0, it sets its flag and reloads from its load register (address 8+i).
- R4: Bit i of the select register (address 1) picks prescaler A (0) or B (1) for channel i. Changing the bit redirects the next tick at once and leaves the channel's current count (address 12+i) unchanged.
- R5: Bit i of the flag register (address 3) is set by channel i's time-out. Writing 1 to bit i clears it, and writing 0 leaves it unchanged.
- R6: If a time-out and a clearing write hit the same flag in the same cycle, the flag stays set.
- R7: `irq[i]` equals flag i AND enable bit i (address 2) in every cycle. Setting an enable bit while its flag is already set raises `irq[i]` in the cycle right after the write.
- R8: The select and enable registers keep only bits 3:0. Writes to bits 7:4 are ignored, and those bits read as 0.
- R9: While the run bit (address 0, bit 0) is 0, prescalers hold their reload values, each channel count follows its load register, and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| irq | output | 4 | Per-channel interrupt request levels |

## Verification
A channel's time-out can land in the same cycle as a software write to the flag register that clears that same flag. The bench forces this by setting one prescaler's reload to 0 and one channel's load to 0, so that channel times out on every cycle, and then issues the clearing write. A behavioural model applies the set after the clear, so the bench expects the flag to stay set and compares it on every clock. An enable write that lands on an already-set flag is the second collision, and it is judged on `irq` in the cycle after the write.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
    localparam int ADR_CTRL  = 0;
    localparam int ADR_SEL   = 1;
    localparam int ADR_INTEN = 2;
    localparam int ADR_FLAGS = 3;
    localparam int ADR_PRE   = 4;
    localparam int ADR_LOAD  = 8;
    localparam int ADR_COUNT = 12;
    localparam int NUM_PRE   = 2;
endpackage

// File: rtl/pit_prescaler.sv
`timescale 1ns/1ps
module pit_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] reload,
    output logic          tick
);
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == '0);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = reload;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: after a tick the count restarts at the reload value
    a_r2_tick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == $past(reload));
    // R9: a stopped prescaler holds its reload value
    a_r9_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == $past(reload));
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] load,
    output logic [CW-1:0] count,
    output logic          timeout
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        timeout = run && tick && (cnt_q == '0);
        cnt_d   = cnt_q;
        if (!run || timeout) begin
            cnt_d = load;
        end else if (tick) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R3: without a tick a running counter keeps its value
    a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));
    // R3: on time-out the counter restarts from the load value
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> cnt_q == $past(load));
endmodule

// File: rtl/pit_quad.sv
`timescale 1ns/1ps
module pit_quad #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int PW  = 8,
    parameter int DW  = 16,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    import pit_pkg::*;

    localparam int NB = NUM_PRE;

    typedef struct packed {
        logic                   run;
        logic [NCH-1:0]         sel;
        logic [NCH-1:0]         inten;
        logic [NCH-1:0]         flags;
        logic [NB-1:0][PW-1:0]  pre_rl;
        logic [NCH-1:0][CW-1:0] load;
    } regs_t;

    regs_t r_d, r_q;

    logic [NB-1:0]          pre_tick;
    logic [NCH-1:0]         ch_tmo;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [NCH-1:0]         clr_mask;

    for (genvar b = 0; b < NB; b++) begin : g_pre
        pit_prescaler #(.PW(PW)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (r_q.run),
            .reload (r_q.pre_rl[b]),
            .tick   (pre_tick[b])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pit_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (r_q.run),
            .tick    (pre_tick[r_q.sel[i]]),
            .load    (r_q.load[i]),
            .count   (ch_cnt[i]),
            .timeout (ch_tmo[i])
        );
    end

    always_comb begin
        r_d      = r_q;
        clr_mask = '0;
        if (bus_wr && bus_addr == AW'(ADR_FLAGS)) begin
            clr_mask = bus_wdata[NCH-1:0];
        end
        r_d.flags = (r_q.flags & ~clr_mask) | ch_tmo;
        if (bus_wr) begin
            if (bus_addr == AW'(ADR_CTRL))  r_d.run   = bus_wdata[0];
            if (bus_addr == AW'(ADR_SEL))   r_d.sel   = bus_wdata[NCH-1:0];
            if (bus_addr == AW'(ADR_INTEN)) r_d.inten = bus_wdata[NCH-1:0];
            for (int b = 0; b < NB; b++) begin
                if (bus_addr == AW'(ADR_PRE + b)) r_d.pre_rl[b] = bus_wdata[PW-1:0];
            end
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == AW'(ADR_LOAD + i)) r_d.load[i] = bus_wdata[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADR_CTRL))  bus_rdata = DW'(r_q.run);
        if (bus_addr == AW'(ADR_SEL))   bus_rdata = DW'(r_q.sel);
        if (bus_addr == AW'(ADR_INTEN)) bus_rdata = DW'(r_q.inten);
        if (bus_addr == AW'(ADR_FLAGS)) bus_rdata = DW'(r_q.flags);
        for (int b = 0; b < NB; b++) begin
            if (bus_addr == AW'(ADR_PRE + b)) bus_rdata = DW'(r_q.pre_rl[b]);
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(ADR_LOAD + i))  bus_rdata = DW'(r_q.load[i]);
            if (bus_addr == AW'(ADR_COUNT + i)) bus_rdata = DW'(ch_cnt[i]);
        end
    end

    assign irq = r_q.flags & r_q.inten;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5: a time-out always leaves the flag set (also R6 when a clear collides)
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ch_tmo[i] |=> r_q.flags[i]);
        // R5: a clearing write with no time-out drops the flag
        a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == AW'(ADR_FLAGS) && bus_wdata[i] && !ch_tmo[i])
            |=> !r_q.flags[i]);
        // R7: enabling a pending flag raises the request right away
        a_r7_enable_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == AW'(ADR_INTEN) && bus_wdata[i] && r_q.flags[i])
            |=> irq[i]);
    end

    // R9: no time-out while stopped
    a_r9_no_timeout_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.run |-> ch_tmo == '0);
endmodule

// File: tb/pit_quad_test.sv
`timescale 1ns/1ps
module pit_quad_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq;

    always #2 clk = ~clk;

    pit_quad uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int checks = 0;
    int fails  = 0;

    bit       m_run;
    bit [3:0] m_sel, m_inten, m_flags;
    int       m_prl[2], m_pc[2], m_ld[4], m_cc[4];

    task automatic chk(string rq, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int exp_read(int a);
        case (a)
            0: return int'(m_run);
            1: return int'(m_sel);
            2: return int'(m_inten);
            3: return int'(m_flags);
            4: return m_prl[0];
            5: return m_prl[1];
            8, 9, 10, 11: return m_ld[a-8];
            12, 13, 14, 15: return m_cc[a-12];
            default: return 0;
        endcase
    endfunction

    function automatic string tag(int a);
        if (a == 0) return "R9";
        if (a == 1 || a == 2) return "R8";
        if (a == 3) return "R5";
        if (a == 4 || a == 5) return "R2";
        if (a >= 12) return "R4";
        return "R3";
    endfunction

    // reference model, advanced on every rising edge, then compared
    always @(posedge clk) begin
        bit [1:0] tk;
        bit [3:0] setm;
        bit [3:0] clr;
        if (!rst_n) begin
            m_run = 0; m_sel = 0; m_inten = 0; m_flags = 0;
            for (int b = 0; b < 2; b++) begin m_prl[b] = 0; m_pc[b] = 0; end
            for (int i = 0; i < 4; i++) begin m_ld[i] = 0; m_cc[i] = 0; end
        end else begin
            for (int b = 0; b < 2; b++) tk[b] = m_run && (m_pc[b] == 0);
            setm = 0;
            for (int i = 0; i < 4; i++) begin
                if (!m_run) m_cc[i] = m_ld[i];
                else if (tk[m_sel[i]]) begin
                    if (m_cc[i] == 0) begin setm[i] = 1; m_cc[i] = m_ld[i]; end
                    else m_cc[i] = m_cc[i] - 1;
                end
            end
            for (int b = 0; b < 2; b++) begin
                if (!m_run || m_pc[b] == 0) m_pc[b] = m_prl[b];
                else m_pc[b] = m_pc[b] - 1;
            end
            clr = (bus_wr && bus_addr == 4'd3) ? bus_wdata[3:0] : 4'd0;
            m_flags = (m_flags & ~clr) | setm;
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: m_run = bus_wdata[0];
                    1: m_sel = bus_wdata[3:0];
                    2: m_inten = bus_wdata[3:0];
                    4: m_prl[0] = int'(bus_wdata[7:0]);
                    5: m_prl[1] = int'(bus_wdata[7:0]);
                    8, 9, 10, 11: m_ld[int'(bus_addr)-8] = int'(bus_wdata);
                    default: ;
                endcase
            end
        end
        #1;
        chk("R7", int'(irq), int'(m_flags & m_inten));
        chk(rst_n ? tag(int'(bus_addr)) : "R1", int'(bus_rdata), exp_read(int'(bus_addr)));
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        bus_addr = 4'(a);
        @(posedge clk);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, c1, c2, c3, c4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin rd(a, v); chk("R1", v, 0); end
        chk("R1", int'(irq), 0);
        // R8 reserved bits
        wr(1, 'hFA); rd(1, v); chk("R8", v, 'hA);
        wr(2, 'hF0); rd(2, v); chk("R8", v, 0);
        // configure prescalers and loads
        wr(4, 3); wr(5, 7);
        wr(8, 5); wr(9, 2); wr(10, 10); wr(11, 0);
        rd(12, v); chk("R9", v, 5);
        wr(0, 1);
        repeat (200) @(posedge clk);
        rd(3, v); chk("R3", v, 'hF);
        // R5 write-one-to-clear, with counting stopped
        wr(0, 0);
        wr(3, 0); rd(3, v); chk("R5", v, 'hF);
        wr(3, 5); rd(3, v); chk("R5", v, 'hA);
        // R7 enabling a pending flag
        wr(2, 2); chk("R7", int'(irq), 2);
        wr(2, 0); chk("R7", int'(irq), 0);
        // R6 set beats clear: channel 0 times out every cycle
        wr(4, 0); wr(8, 0); wr(1, 0); wr(0, 1);
        repeat (3) @(posedge clk);
        wr(3, 1); rd(3, v); chk("R6", v & 1, 1);
        // R4 switching tick source keeps the count
        wr(0, 0); wr(10, 1000); wr(5, 200); wr(0, 1);
        repeat (10) @(posedge clk);
        wr(1, 4);
        rd(14, c1);
        chk("R4", int'(c1 < 1000 && c1 > 900), 1);
        repeat (5) @(posedge clk);
        rd(14, c2); chk("R4", c2, c1);
        wr(1, 0);
        rd(14, c3);
        repeat (5) @(posedge clk);
        rd(14, c4); chk("R4", c4, c3 - 6);
        // R9 stopped: counts follow loads, flags stay
        wr(0, 0);
        repeat (2) @(posedge clk);
        rd(14, v); chk("R9", v, 1000);
        rd(3, c1);
        repeat (20) @(posedge clk);
        rd(3, c2); chk("R9", c2, c1);
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule